// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Initiator

This block is the master side of a parallel bus on which address and data share one set of tri-state lines. A user request gives a start address, a bus command and a beat count. The block waits until it holds the grant and the bus is idle. It then drives one address/command cycle and leaves the shared lines undriven for one turnaround cycle. After that it gathers data beats from the target. Every control line is active low and is sampled on the rising clock edge.

A beat is taken only on an edge where both the initiator-ready and the target-ready lines are low. If either line is high, that cycle is a wait state. The user side can insert initiator wait states through a buffer-full input. The block signals the last beat by releasing the frame line during the final data phase. When the burst ends it hands control back: the frame, address/data and command/byte-enable lines go undriven, and initiator-ready is driven high for one cycle before it too is released.

If the target never claims the cycle through its device-select line, a counter ends the transaction and reports an error. Each tri-state line is brought out as a value and enable pair, so the pads can be placed in the chip's I/O ring.

Top module: `pbr_burst_reader`

## Requirements
- R1: While reset is low and after it, until a request is accepted, all output enables (ad_oe, cbe_oe, frame_oe, irdy_oe) are low and rd_valid, done, err and busy are low.
- R2: A start pulse is ignored when req_beats is 0 or while busy is high: busy stays low in the first case, and the burst in progress keeps the address and command latched when it was accepted.
- R3: The address phase starts only on an edge where gnt_n is low and the bus is idle, meaning frame_in and irdy_in are both high. In the cycle after that edge frame_n is driven 0, ad_out carries the request address, cbe_out carries the command and irdy_n is driven 1.
- R4: The cycle after the address phase is a turnaround cycle. In it ad_oe is low, cbe_out is driven 4'b0000 (all bytes enabled), and no beat is taken even if trdy_n is low.
- R5: A beat is taken on an edge where irdy_n and trdy_n are both low during a data phase. In the following cycle rd_valid is high for one cycle and rd_data holds the ad_in value sampled at that edge. No other cycle raises rd_valid.
- R6: In turnaround and data cycles, irdy_n is driven 1 while usr_full is high and the final phase has not begun, and is driven 0 otherwise.
- R7: frame_n stays driven 0 while more than one beat remains. It goes to 1 only together with irdy_n at 0 while exactly one beat remains. Once it is 1, irdy_n stays 0 and frame_n stays 1 until that beat is taken, whatever usr_full does.
- R8: In the cycle after the last beat is taken, done is high for one cycle, ad_oe, cbe_oe and frame_oe are low, and irdy_n is driven 1. In the next cycle irdy_oe is low and busy is low.
- R9: If devsel_n is not sampled low in any of the first DSEL_LIMIT cycles after the address phase (turnaround included; default 4), the transaction ends after the last of those cycles. done and err are then high together for one cycle and the lines are released as in R8. A transaction that completes normally leaves err low.
- R10: busy is high from the edge that accepts a request until the cycle after the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request pulse from the user side |
| req_addr | input | AD_W | Start address of the burst |
| req_cmd | input | CBE_W | Bus command driven during the address phase |
| req_beats | input | BEAT_W | Number of data beats, 0 is rejected |
| usr_full | input | 1 | User receive buffer full, stalls the initiator |
| rd_valid | output | 1 | One-cycle strobe for each received beat |
| rd_data | output | AD_W | Received beat |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | One-cycle pulse with done when device select timed out |
| busy | output | 1 | A transaction is in progress |
| gnt_n | input | 1 | Bus grant for this device, active low |
| frame_in | input | 1 | Resolved frame line on the bus |
| irdy_in | input | 1 | Resolved initiator-ready line on the bus |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select from the target, active low |
| ad_in | input | AD_W | Address/data lines as seen on the bus |
| ad_out | output | AD_W | Address/data value to drive |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_out | output | CBE_W | Command / byte-enable value to drive |
| cbe_oe | output | 1 | Drive enable for cbe_out |
| frame_n | output | 1 | Frame value to drive |
| frame_oe | output | 1 | Drive enable for frame_n |
| irdy_n | output | 1 | Initiator-ready value to drive |
| irdy_oe | output | 1 | Drive enable for irdy_n |

## Verification
Bursts of one to eight beats are run against a bench target. In one group the target alone inserts wait states and the user side is never full; this separates target-side stalls from initiator-side ones. In another group usr_full is raised in the turnaround cycle and at the final beat, which shows whether the frame release waits for initiator-ready and whether it holds once begun. Requests are also made while grant is withheld or while another master keeps initiator-ready low, and repeated start pulses during the wait show that the first request is kept. Finally, a target that never asserts device select checks the timeout count and the error pulse.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_TAR  = 3'd3,
    ST_DATA = 3'd4,
    ST_END  = 3'd5
  } pbr_state_e;

  // Bus is free only when neither frame nor initiator-ready is low.
  function automatic logic bus_is_idle(input logic frame_l, input logic irdy_l);
    return frame_l & irdy_l;
  endfunction

  // Turnaround and data cycles share the same control rules.
  function automatic logic is_data_cycle(input pbr_state_e st);
    return (st == ST_TAR) || (st == ST_DATA);
  endfunction

endpackage

// File: rtl/pbr_seq.sv
module pbr_seq
  import pbr_pkg::*;
#(
  parameter int BEAT_W     = 8,
  parameter int DSEL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              gnt_n,
  input  logic              frame_in,
  input  logic              irdy_in,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic              usr_full,
  output pbr_state_e        state,
  output logic              accept,
  output logic              in_data,
  output logic              irdy_act,
  output logic              final_ph,
  output logic              xfer,
  output logic              last_xfer,
  output logic              timeout,
  output logic              busy
);

  localparam int CNT_W = $clog2(DSEL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DSEL_LIMIT - 1);

  pbr_state_e        state_q, state_d;
  logic [BEAT_W-1:0] rem_q;
  logic              last_q;
  logic              dev_seen_q;
  logic [CNT_W-1:0]  dcnt_q;

  function automatic logic one_left(input logic [BEAT_W-1:0] r);
    return r == BEAT_W'(1);
  endfunction

  assign state    = state_q;
  assign busy     = (state_q != ST_IDLE);
  assign in_data  = is_data_cycle(state_q);
  assign accept   = (state_q == ST_IDLE) && req_start && (req_beats != '0);
  assign irdy_act = in_data && (last_q || !usr_full);
  assign final_ph = irdy_act && one_left(rem_q);
  assign xfer     = (state_q == ST_DATA) && irdy_act && !trdy_n;
  assign last_xfer = xfer && one_left(rem_q);
  assign timeout  = in_data && !dev_seen_q && devsel_n && (dcnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_REQ;
      ST_REQ:  if (!gnt_n && bus_is_idle(frame_in, irdy_in)) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_TAR;
      ST_TAR:  state_d = timeout ? ST_END : ST_DATA;
      ST_DATA: if (timeout || last_xfer) state_d = ST_END;
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      last_q     <= 1'b0;
      dev_seen_q <= 1'b0;
      dcnt_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        rem_q <= req_beats;
      end else if (xfer) begin
        rem_q <= rem_q - BEAT_W'(1);
      end
      if (state_q == ST_ADDR) begin
        last_q     <= 1'b0;
        dev_seen_q <= 1'b0;
        dcnt_q     <= '0;
      end else if (in_data) begin
        if (final_ph && !xfer) last_q <= 1'b1;
        if (!devsel_n) dev_seen_q <= 1'b1;
        else if (!dev_seen_q && !timeout) dcnt_q <= dcnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pbr_drv.sv
module pbr_drv
  import pbr_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = AD_W / 8
) (
  input  pbr_state_e       state,
  input  logic             in_data,
  input  logic             irdy_act,
  input  logic             final_ph,
  input  logic [AD_W-1:0]  addr_q,
  input  logic [CBE_W-1:0] cmd_q,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic [CBE_W-1:0] cbe_out,
  output logic             cbe_oe,
  output logic             frame_n,
  output logic             frame_oe,
  output logic             irdy_n,
  output logic             irdy_oe
);

  always_comb begin
    ad_out   = '0;
    ad_oe    = 1'b0;
    cbe_out  = '0;
    cbe_oe   = 1'b0;
    frame_n  = 1'b1;
    frame_oe = 1'b0;
    irdy_n   = 1'b1;
    irdy_oe  = 1'b0;
    if (state == ST_ADDR) begin
      ad_out   = addr_q;
      ad_oe    = 1'b1;
      cbe_out  = cmd_q;
      cbe_oe   = 1'b1;
      frame_n  = 1'b0;
      frame_oe = 1'b1;
      irdy_oe  = 1'b1;
    end else if (in_data) begin
      cbe_oe   = 1'b1;
      frame_n  = final_ph;
      frame_oe = 1'b1;
      irdy_n   = !irdy_act;
      irdy_oe  = 1'b1;
    end else if (state == ST_END) begin
      irdy_oe  = 1'b1;
    end
  end

endmodule

// File: rtl/pbr_rx.sv
module pbr_rx #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer,
  input  logic            last_xfer,
  input  logic            timeout,
  input  logic [AD_W-1:0] ad_in,
  output logic            rd_valid,
  output logic [AD_W-1:0] rd_data,
  output logic            done,
  output logic            err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= xfer;
      if (xfer) rd_data <= ad_in;
      done <= last_xfer || timeout;
      err  <= timeout;
    end
  end

endmodule

// File: rtl/pbr_burst_reader.sv
module pbr_burst_reader
  import pbr_pkg::*;
#(
  parameter int AD_W       = 32,
  parameter int CBE_W      = AD_W / 8,
  parameter int BEAT_W     = 8,
  parameter int DSEL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [AD_W-1:0]   req_addr,
  input  logic [CBE_W-1:0]  req_cmd,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              usr_full,
  output logic              rd_valid,
  output logic [AD_W-1:0]   rd_data,
  output logic              done,
  output logic              err,
  output logic              busy,
  input  logic              gnt_n,
  input  logic              frame_in,
  input  logic              irdy_in,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [CBE_W-1:0]  cbe_out,
  output logic              cbe_oe,
  output logic              frame_n,
  output logic              frame_oe,
  output logic              irdy_n,
  output logic              irdy_oe
);

  pbr_state_e       state;
  logic             accept, in_data, irdy_act, final_ph;
  logic             xfer, last_xfer, timeout;
  logic [AD_W-1:0]  addr_q;
  logic [CBE_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      cmd_q  <= req_cmd;
    end
  end

  pbr_seq #(.BEAT_W(BEAT_W), .DSEL_LIMIT(DSEL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_beats(req_beats),
    .gnt_n(gnt_n), .frame_in(frame_in), .irdy_in(irdy_in), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .usr_full(usr_full), .state(state), .accept(accept),
    .in_data(in_data), .irdy_act(irdy_act), .final_ph(final_ph), .xfer(xfer),
    .last_xfer(last_xfer), .timeout(timeout), .busy(busy)
  );

  pbr_drv #(.AD_W(AD_W), .CBE_W(CBE_W)) u_drv (
    .state(state), .in_data(in_data), .irdy_act(irdy_act), .final_ph(final_ph),
    .addr_q(addr_q), .cmd_q(cmd_q), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_n(frame_n), .frame_oe(frame_oe),
    .irdy_n(irdy_n), .irdy_oe(irdy_oe)
  );

  pbr_rx #(.AD_W(AD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .last_xfer(last_xfer),
    .timeout(timeout), .ad_in(ad_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .err(err)
  );

endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt_n,
  input logic             frame_in,
  input logic             irdy_in,
  input logic             trdy_n,
  input logic             usr_full,
  input logic             frame_n,
  input logic             frame_oe,
  input logic             irdy_n,
  input logic             irdy_oe,
  input logic             ad_oe,
  input logic [CBE_W-1:0] cbe_out,
  input logic             cbe_oe,
  input logic             rd_valid,
  input logic             done,
  input logic             err,
  input logic             busy,
  input logic             in_data,
  input logic             last_hold
);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!frame_oe && !ad_oe && !cbe_oe && !irdy_oe && !rd_valid));

  p_addr_on_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_oe) |-> ($past(!gnt_n && frame_in && irdy_in) && !frame_n && ad_oe));

  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ad_oe) |-> (cbe_oe && cbe_out == '0 && frame_oe));

  p_beat_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(irdy_oe && !irdy_n && !trdy_n));

  p_full_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && usr_full && !last_hold) |-> irdy_n);

  p_frame_end_with_irdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && frame_n) |-> (irdy_oe && !irdy_n));

  p_frame_no_reassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_oe && frame_n) && frame_oe) |-> frame_n);

  p_done_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!frame_oe && !ad_oe && !cbe_oe && irdy_oe && irdy_n));

  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!irdy_oe && !busy));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind pbr_burst_reader pbr_checker #(.CBE_W(CBE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .frame_in(frame_in),
  .irdy_in(irdy_in), .trdy_n(trdy_n), .usr_full(usr_full), .frame_n(frame_n),
  .frame_oe(frame_oe), .irdy_n(irdy_n), .irdy_oe(irdy_oe), .ad_oe(ad_oe),
  .cbe_out(cbe_out), .cbe_oe(cbe_oe), .rd_valid(rd_valid), .done(done),
  .err(err), .busy(busy), .in_data(u_seq.in_data), .last_hold(u_seq.last_q)
);

// File: tb/test_pbr_burst_reader.sv
module test_pbr_burst_reader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [7:0]  req_beats = '0;
  logic        usr_full = 1'b0;
  logic        rd_valid, done, err, busy;
  logic [31:0] rd_data;
  logic        gnt_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_out;
  logic        cbe_oe, frame_n, frame_oe, irdy_n, irdy_oe;
  logic        ext_frame_n = 1'b1;
  logic        ext_irdy_n = 1'b1;
  logic        frame_in, irdy_in;

  int n_chk = 0;
  int n_fail = 0;

  assign frame_in = frame_oe ? frame_n : ext_frame_n;
  assign irdy_in  = irdy_oe ? irdy_n : ext_irdy_n;

  always #5 clk = ~clk;

  pbr_burst_reader i_pbr_burst_reader (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_beats(req_beats), .usr_full(usr_full),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err), .busy(busy),
    .gnt_n(gnt_n), .frame_in(frame_in), .irdy_in(irdy_in), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_n(frame_n), .frame_oe(frame_oe),
    .irdy_n(irdy_n), .irdy_oe(irdy_oe)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [7:0]  beats;
    logic [7:0]  wpat;   // bit set: target waits in that data cycle
    logic [7:0]  fpat;   // bit set: user side full in that cycle
    logic [3:0]  hold;   // cycles before grant and idle bus
    logic        hbusy;  // hold by a busy bus rather than by no grant
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 4'h6, 8'd1, 8'h00, 8'h00, 4'd0, 1'b0},
    '{32'h0000_2040, 4'h6, 8'd3, 8'h02, 8'h00, 4'd1, 1'b0},
    '{32'h8000_0100, 4'hC, 8'd4, 8'h00, 8'h04, 4'd2, 1'b1},
    '{32'h1234_5678, 4'hE, 8'd5, 8'h55, 8'h30, 4'd0, 1'b0},
    '{32'hFFFF_FFFC, 4'h6, 8'd2, 8'h00, 8'h03, 4'd3, 1'b0},
    '{32'h0000_0000, 4'h6, 8'd8, 8'h81, 8'h42, 4'd1, 1'b1},
    '{32'h00C0_FFEE, 4'h6, 8'd1, 8'h01, 8'h03, 4'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Target-side data pattern, written independently of the design.
  function automatic logic [31:0] beat_val(input logic [31:0] a, input int k);
    return (a + 32'(k * 4)) ^ 32'h5A5A_0000;
  endfunction

  task automatic run_txn(input vec_t v);
    int rem = int'(v.beats);
    int k = 0;
    bit last_seen = 1'b0;
    bit pend = 1'b0;
    bit exp_act;
    logic [31:0] pend_data = '0;
    @(negedge clk);
    req_start = 1'b1; req_addr = v.addr; req_cmd = v.cmd; req_beats = v.beats;
    gnt_n = (v.hold != 0 && !v.hbusy);
    ext_irdy_n = !(v.hold != 0 && v.hbusy);
    for (int h = 0; h < int'(v.hold); h++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
      chk(frame_oe == 1'b0, "R3 no address phase without grant and idle bus", 64'(frame_oe), 64'd0);
      req_start = 1'b1; req_addr = ~v.addr; req_cmd = ~v.cmd; req_beats = 8'd7;  // R2 start while busy
    end
    @(negedge clk);
    req_start = 1'b0; gnt_n = 1'b0; ext_irdy_n = 1'b1;
    chk(frame_oe == 1'b0, "R3 still waiting before grant edge", 64'(frame_oe), 64'd0);
    @(negedge clk);
    chk(frame_oe && !frame_n, "R3 frame asserted in address phase", {62'd0, frame_oe, frame_n}, 64'd2);
    chk(ad_oe && ad_out == v.addr, "R3 R2 address on AD", 64'(ad_out), 64'(v.addr));
    chk(cbe_oe && cbe_out == v.cmd, "R3 R2 command on C/BE", 64'(cbe_out), 64'(v.cmd));
    chk(irdy_oe && irdy_n, "R3 irdy high in address phase", 64'(irdy_n), 64'd1);
    gnt_n = 1'b1;
    for (int j = 0; j < 64 && rem > 0; j++) begin
      @(negedge clk);
      chk(rd_valid == pend, "R5 rd_valid after handshake", 64'(rd_valid), 64'(pend));
      if (pend) chk(rd_data == pend_data, "R5 rd_data", 64'(rd_data), 64'(pend_data));
      if (j == 0) begin
        trdy_n = 1'b1; devsel_n = 1'b1; usr_full = v.fpat[0];
      end else begin
        trdy_n = v.wpat[(j - 1) % 8]; devsel_n = 1'b0; usr_full = v.fpat[j % 8];
      end
      ad_in = beat_val(v.addr, k);
      #1;
      if (j == 0) chk(!ad_oe && cbe_oe && cbe_out == 4'h0, "R4 turnaround releases AD",
                      {59'd0, ad_oe, cbe_out}, 64'd0);
      exp_act = last_seen || !usr_full;
      chk(irdy_oe && (irdy_n == !exp_act), "R6 irdy from user full", 64'(irdy_n), 64'(!exp_act));
      chk(frame_oe && (frame_n == (rem == 1 && exp_act)), "R7 frame release",
          64'(frame_n), 64'(rem == 1 && exp_act));
      pend = (j > 0) && exp_act && !trdy_n;
      if (rem == 1 && exp_act && !pend) last_seen = 1'b1;
      if (pend) begin
        pend_data = beat_val(v.addr, k);
        k++;
        rem--;
      end
    end
    @(negedge clk);
    trdy_n = 1'b1; devsel_n = 1'b1; usr_full = 1'b0;
    chk(rd_valid && rd_data == pend_data, "R5 last beat data", 64'(rd_data), 64'(pend_data));
    chk(done == 1'b1 && err == 1'b0, "R8 R9 done without err", {62'd0, done, err}, 64'd2);
    chk(!frame_oe && !ad_oe && !cbe_oe && irdy_oe && irdy_n, "R8 release cycle",
        {59'd0, frame_oe, ad_oe, cbe_oe, irdy_oe, irdy_n}, 64'd3);
    @(negedge clk);
    chk(!irdy_oe && !done && !busy && !rd_valid, "R8 R10 back to idle",
        {60'd0, irdy_oe, done, busy, rd_valid}, 64'd0);
    chk(k == int'(v.beats), "R5 beat count", 64'(k), 64'(v.beats));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ad_oe && !cbe_oe && !frame_oe && !irdy_oe, "R1 enables low in reset",
        {60'd0, ad_oe, cbe_oe, frame_oe, irdy_oe}, 64'd0);
    chk(!rd_valid && !done && !err && !busy, "R1 status low in reset",
        {60'd0, rd_valid, done, err, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !frame_oe, "R1 idle after reset", {62'd0, busy, frame_oe}, 64'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) run_txn(VECS[i]);

    // R2: zero beat count is rejected
    @(negedge clk);
    req_start = 1'b1; req_addr = 32'hDEAD_0000; req_beats = 8'd0; gnt_n = 1'b0;
    @(negedge clk);
    req_start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!busy && !frame_oe && !ad_oe, "R2 zero beats ignored",
          {61'd0, busy, frame_oe, ad_oe}, 64'd0);
    end

    // R9: target never claims the cycle
    req_start = 1'b1; req_addr = 32'h0000_4000; req_cmd = 4'h6; req_beats = 8'd3;
    devsel_n = 1'b1; trdy_n = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    chk(frame_oe && !frame_n, "R9 address phase before timeout", 64'(frame_n), 64'd0);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      chk(!done && !err && frame_oe, "R9 no early timeout", {61'd0, done, err, frame_oe}, 64'd1);
    end
    @(negedge clk);
    chk(done && err, "R9 timeout raises done and err", {62'd0, done, err}, 64'd3);
    chk(!frame_oe && !ad_oe && !cbe_oe && irdy_oe && irdy_n, "R9 lines released",
        {59'd0, frame_oe, ad_oe, cbe_oe, irdy_oe, irdy_n}, 64'd3);
    @(negedge clk);
    chk(!done && !err && !busy && !irdy_oe, "R9 one-cycle error pulse",
        {60'd0, done, err, busy, irdy_oe}, 64'd0);
    gnt_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule